// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block walks a list of receive descriptors held in host memory and hands each descriptor, with its data buffer, back to software. A frame arriving on the byte stream is spread over as many fixed-size buffers as it needs. As soon as a buffer is full and more bytes follow, its descriptor is released by clearing the ownership bit. Software can then start on that part of the frame while the rest is still arriving. When the last byte arrives, one completion word is built. If the frame used several descriptors, it is written to the descriptor that opened the frame and then to the one that closed it. If the frame used one descriptor, it is written once.

Descriptors are 16-byte records. The engine reads the ownership word at offset 0 and the control word at offset 4. When the control word marks the record as chained, it also reads a next pointer at offset 12. Ring and chain links can be mixed freely in one list. The data path, bus mastering and address filtering sit outside the block. The engine only counts bytes and stalls the stream (`rx_ready_o` low) while it talks to memory.

Top module: `rxwb_engine`

## Requirements
- R1: After reset the engine issues no memory request, holds `rx_ready_o` low, clears `desc_unavail_o` and takes `RING_BASE` as the current descriptor address.
- R2: A byte with `rx_sof_i` arriving while idle starts a fetch of the current descriptor: a read at offset 0, then a read at offset 4. A read at offset 12 follows only when control bit 24 (chain) is set.
- R3: `rx_ready_o` is high only while a hardware-owned descriptor is loaded for receiving, or while a frame is being discarded. It is never high while a memory request is pending.
- R4: When the buffer reaches `BUF_BYTES` bytes and the byte that filled it does not end the frame, the engine writes word 0 of that descriptor before it accepts another byte. The word has bit 31 (own) = 0, bit 30 (done) = 0, bit 28 (last) = 0, length and error fields zero, and bit 29 (first) = 1 only for the frame's first descriptor.
- R5: At end of frame the status word has own = 0, done = 1, last = 1, bits 26:24 = the `rx_err_i` value given with the final byte, and bits 15:0 = the length.
- R6: A frame spanning several descriptors gets two identical status writes with first = 0: one to the first descriptor, then one to the last. A frame that fits in one buffer gets exactly one write, with first = 1.
- R7: The length field counts every byte of the frame across all of its buffers.
- R8: An unchained descriptor is followed by the record 16 bytes above it. When control bit 25 (end of ring) is set, it is followed by `RING_BASE` instead.
- R9: A chained descriptor is followed by the address read from its offset 12. Chain takes priority over end of ring.
- R10: If an ownership read returns bit 31 = 0, `desc_unavail_o` rises and nothing is written to that descriptor. The rest of the frame is accepted and discarded. The same descriptor is read again on the next start of frame, and the flag clears once that read finds it hardware-owned.
- R11: A memory request keeps its address, write enable and write data unchanged until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A frame byte is present |
| rx_sof_i | input | 1 | Present byte opens a frame |
| rx_eof_i | input | 1 | Present byte closes a frame |
| rx_err_i | input | ERR_W | Error type, taken with the closing byte |
| rx_ready_o | output | 1 | Byte is taken this cycle when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the descriptor word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| desc_unavail_o | output | 1 | Last ownership read found a software-owned descriptor |

## Verification
The hardest state to reach is a descriptor that software still owns while a frame is in progress. The engine must release the earlier buffer, stop, and then swallow the tail of the frame without writing anything. The bench overrides `BUF_BYTES` to 4 so that short frames cross buffer boundaries. Just before sending a seven-byte frame, it clears the ownership word of the descriptor that follows the current one. Walking the ring of four records through a table of frames forces wraparound. A two-link chain that leaves the ring and comes back exercises the next-pointer path.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_OWN, ST_RD_CTL, ST_RD_NXT, ST_RECV,
    ST_REL, ST_FIN_A, ST_FIN_B, ST_DROP
  } rxwb_state_e;

  localparam int OWN_BIT    = 31;
  localparam int DONE_BIT   = 30;
  localparam int FS_BIT     = 29;
  localparam int LS_BIT     = 28;
  localparam int ERR_LSB    = 24;
  localparam int EOR_BIT    = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int OFS_OWN    = 0;
  localparam int OFS_CTL    = 4;
  localparam int OFS_NXT    = 12;
  localparam int DESC_BYTES = 16;
endpackage

// File: rtl/rxwb_status.sv
module rxwb_status
  import rxwb_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ERR_W = 3
) (
  input  logic             done_i,
  input  logic             fs_i,
  input  logic             ls_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [31:0]      word_o
);
  always_comb begin
    word_o                   = '0;
    word_o[DONE_BIT]         = done_i;
    word_o[FS_BIT]           = fs_i;
    word_o[LS_BIT]           = ls_i;
    word_o[ERR_LSB +: ERR_W] = err_i;
    word_o[LEN_W-1:0]        = len_i;
  end
endmodule

// File: rtl/rxwb_next.sv
module rxwb_next
  import rxwb_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] RING_BASE = '0
) (
  input  logic [AW-1:0] cur_i,
  input  logic          chain_i,
  input  logic          eor_i,
  input  logic [31:0]   ptr_i,
  output logic [AW-1:0] nxt_o
);
  always_comb begin
    if (chain_i)    nxt_o = ptr_i[AW-1:0];
    else if (eor_i) nxt_o = RING_BASE[AW-1:0];
    else            nxt_o = cur_i + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          BUF_BYTES = 2048,
  parameter int          LEN_W     = 16,
  parameter int          ERR_W     = 3,
  parameter logic [31:0] RING_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic [ERR_W-1:0] rx_err_i,
  output logic             rx_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             desc_unavail_o
);
  localparam int BCW = (BUF_BYTES > 2) ? $clog2(BUF_BYTES) : 1;
  localparam logic [BCW-1:0] BUF_LAST = BCW'(BUF_BYTES - 1);

  rxwb_state_e      state;
  logic [AW-1:0]    cur_addr, nxt_addr, first_addr, nxt_calc;
  logic             chain_q, eor_q, seg_first, unavail_q;
  logic [BCW-1:0]   buf_cnt;
  logic [LEN_W-1:0] frame_len;
  logic [ERR_W-1:0] err_q;
  logic             st_done;
  logic [31:0]      st_word;

  rxwb_next #(.AW(AW), .RING_BASE(RING_BASE)) u_next (
    .cur_i   (cur_addr),
    .chain_i (chain_q),
    .eor_i   (eor_q),
    .ptr_i   (mem_rdata_i),
    .nxt_o   (nxt_calc)
  );

  assign st_done = (state != ST_REL);

  rxwb_status #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_status (
    .done_i (st_done),
    .fs_i   (seg_first),
    .ls_i   (st_done),
    .err_i  (st_done ? err_q : '0),
    .len_i  (st_done ? frame_len : '0),
    .word_o (st_word)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_addr;
    mem_wdata_o = st_word;
    unique case (state)
      ST_RD_OWN: begin mem_req_o = 1'b1; mem_addr_o = cur_addr + AW'(OFS_OWN); end
      ST_RD_CTL: begin mem_req_o = 1'b1; mem_addr_o = cur_addr + AW'(OFS_CTL); end
      ST_RD_NXT: begin mem_req_o = chain_q; mem_addr_o = cur_addr + AW'(OFS_NXT); end
      ST_REL, ST_FIN_B: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      ST_FIN_A: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = seg_first ? cur_addr : first_addr;
      end
      default: ;
    endcase
  end

  assign rx_ready_o     = (state == ST_RECV) || (state == ST_DROP);
  assign desc_unavail_o = unavail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cur_addr   <= RING_BASE[AW-1:0];
      nxt_addr   <= '0;
      first_addr <= '0;
      chain_q    <= 1'b0;
      eor_q      <= 1'b0;
      seg_first  <= 1'b0;
      unavail_q  <= 1'b0;
      buf_cnt    <= '0;
      frame_len  <= '0;
      err_q      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (rx_valid_i) begin
          if (rx_sof_i) begin
            first_addr <= cur_addr;
            seg_first  <= 1'b1;
            frame_len  <= '0;
            buf_cnt    <= '0;
            state      <= ST_RD_OWN;
          end else begin
            state <= ST_DROP;  // stray byte outside a frame
          end
        end
        ST_RD_OWN: if (mem_ack_i) begin
          unavail_q <= ~mem_rdata_i[OWN_BIT];
          state     <= mem_rdata_i[OWN_BIT] ? ST_RD_CTL : ST_DROP;
        end
        ST_RD_CTL: if (mem_ack_i) begin
          chain_q <= mem_rdata_i[CHAIN_BIT];
          eor_q   <= mem_rdata_i[EOR_BIT];
          state   <= ST_RD_NXT;
        end
        ST_RD_NXT: if (!chain_q || mem_ack_i) begin
          nxt_addr <= nxt_calc;
          state    <= ST_RECV;
        end
        ST_RECV: if (rx_valid_i) begin
          frame_len <= frame_len + LEN_W'(1);
          if (rx_eof_i) begin
            err_q <= rx_err_i;
            state <= ST_FIN_A;
          end else if (buf_cnt == BUF_LAST) begin
            buf_cnt <= '0;
            state   <= ST_REL;
          end else begin
            buf_cnt <= buf_cnt + BCW'(1);
          end
        end
        ST_REL: if (mem_ack_i) begin
          cur_addr  <= nxt_addr;
          seg_first <= 1'b0;
          state     <= ST_RD_OWN;
        end
        ST_FIN_A: if (mem_ack_i) begin
          if (seg_first) begin
            cur_addr <= nxt_addr;
            state    <= ST_IDLE;
          end else begin
            state <= ST_FIN_B;
          end
        end
        ST_FIN_B: if (mem_ack_i) begin
          cur_addr <= nxt_addr;
          state    <= ST_IDLE;
        end
        ST_DROP: if (rx_valid_i && rx_eof_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxwb_engine_chk.sv
module rxwb_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          desc_unavail_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o)); // R11

  AST_NO_READY_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rx_ready_o); // R3

  AST_WRITE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]); // R4

  AST_EARLY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_wdata_o[30] |-> !mem_wdata_o[28] && mem_wdata_o[15:0] == '0); // R4

  AST_FINAL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_wdata_o[30] |-> mem_wdata_o[28]); // R5

  AST_UNAVAIL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_unavail_o |-> !(mem_req_o && mem_we_o)); // R10
endmodule

bind rxwb_engine rxwb_engine_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_ready_o     (rx_ready_o),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_ack_i      (mem_ack_i),
  .desc_unavail_o (desc_unavail_o)
);

// File: tb/rxwb_engine_tb.sv
`timescale 1ns/1ps
module rxwb_engine_tb;
  localparam int          AW    = 32;
  localparam int          BUF   = 4;
  localparam logic [31:0] BASE  = 32'h100;
  localparam int          FR_N  = 6;
  localparam int FR_LEN  [FR_N] = '{1, 4, 5, 9, 8, 13};
  localparam int FR_ERR  [FR_N] = '{0, 2, 0, 5, 1, 0};
  localparam int FR_NDSC [FR_N] = '{1, 1, 2, 3, 2, 4};

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [2:0] rx_err = '0;
  logic rx_ready_o, mem_req_o, mem_we_o, mem_ack, desc_unavail_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata;

  always #2 clk = ~clk;

  rxwb_engine #(.AW(AW), .BUF_BYTES(BUF), .LEN_W(16), .ERR_W(3), .RING_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_err_i(rx_err), .rx_ready_o(rx_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .desc_unavail_o(desc_unavail_o)
  );

  // memory model with transaction log and request-hold monitor
  logic [31:0] mem [0:255];
  logic        t_we   [0:511];
  logic [31:0] t_addr [0:511];
  logic [31:0] t_data [0:511];
  int t_cnt = 0, hold_viol = 0;
  logic pend = 0;
  logic [31:0] paddr = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pend && (!mem_req_o || mem_addr_o != paddr)) hold_viol <= hold_viol + 1;
    pend  <= mem_req_o && !mem_ack;
    paddr <= mem_addr_o;
    if (mem_req_o && !mem_ack && rst_n) begin
      mem_ack <= 1'b1;
      if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      else          mem_rdata <= mem[mem_addr_o[9:2]];
      t_we[t_cnt] <= mem_we_o; t_addr[t_cnt] <= mem_addr_o; t_data[t_cnt] <= mem_we_o ? mem_wdata_o : 32'h0;
      t_cnt <= t_cnt + 1;
    end
  end

  int checks = 0, errors = 0;
  int idx = 0, snap = 0, e_n = 0;
  logic [31:0] e_addr [0:15];
  logic [31:0] e_data [0:15];

  task automatic chk(input bit ok, input string rid, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rid, act, exp);
    end
  endtask

  function automatic logic [31:0] dadr(input int i);
    return BASE + 32'(16 * (i % 4));
  endfunction

  function automatic logic [31:0] st(input bit done, input bit fs, input bit ls, input int err, input int len);
    return (32'(done) << 30) | (32'(fs) << 29) | (32'(ls) << 28) | (32'(err) << 24) | 32'(len);
  endfunction

  task automatic arm_ring();
    for (int d = 0; d < 4; d++) begin
      mem[dadr(d) >> 2]       = 32'h8000_0000;
      mem[(dadr(d) >> 2) + 1] = (d == 3) ? 32'h0200_0000 : 32'h0;
    end
  endtask

  task automatic send_frame(input int len, input int err);
    for (int b = 0; b < len; b++) begin
      rx_valid = 1; rx_sof = (b == 0); rx_eof = (b == len - 1); rx_err = 3'(err);
      while (!rx_ready_o) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = '0;
    repeat (16) @(negedge clk);
  endtask

  task automatic exp_frame(input int first, input int nd, input int err, input int len);
    e_n = 0;
    for (int k = 0; k < nd - 1; k++) begin
      e_addr[e_n] = dadr(first + k); e_data[e_n] = st(0, k == 0, 0, 0, 0); e_n++;
    end
    if (nd > 1) begin
      e_addr[e_n] = dadr(first); e_data[e_n] = st(1, 0, 1, err, len); e_n++;
    end
    e_addr[e_n] = dadr(first + nd - 1); e_data[e_n] = st(1, nd == 1, 1, err, len); e_n++;
  endtask

  task automatic cmp_writes(input string rid);
    int n = 0;
    for (int k = snap; k < t_cnt; k++) begin
      if (t_we[k]) begin
        if (n < e_n) begin
          chk(t_addr[k] == e_addr[n], {rid, " addr"}, t_addr[k], e_addr[n]);
          chk(t_data[k] == e_data[n], {rid, " data"}, t_data[k], e_data[n]);
        end
        n++;
      end
    end
    chk(n == e_n, {rid, " write count"}, 32'(n), 32'(e_n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 256; w++) mem[w] = '0;
    arm_ring();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_req_o && !rx_ready_o && !desc_unavail_o, "R1 reset outputs",
        {29'b0, mem_req_o, rx_ready_o, desc_unavail_o}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!mem_req_o, "R1 idle no request", 32'(mem_req_o), 32'h0);

    // R3/R2: stream stalled during fetch; single-buffer frame
    snap = t_cnt;
    rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_err = 3'd3;
    @(negedge clk);
    chk(!rx_ready_o && mem_req_o, "R3 stalled while fetching", {30'b0, rx_ready_o, mem_req_o}, 32'h1);
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = '0;
    repeat (16) @(negedge clk);
    chk(!t_we[snap] && t_addr[snap] == BASE, "R2 own read first", t_addr[snap], BASE);
    chk(!t_we[snap+1] && t_addr[snap+1] == BASE + 4, "R2 ctl read second", t_addr[snap+1], BASE + 4);
    chk(t_we[snap+2], "R2 no pointer read when unchained", 32'(t_we[snap+2]), 32'h1);
    exp_frame(0, 1, 3, 1);
    cmp_writes("R6 single descriptor one write");
    idx = 1;

    // table: R4 R5 R6 R7 R8 across ring wraps
    for (int i = 0; i < FR_N; i++) begin
      arm_ring();
      snap = t_cnt;
      send_frame(FR_LEN[i], FR_ERR[i]);
      exp_frame(idx, FR_NDSC[i], FR_ERR[i], FR_LEN[i]);
      cmp_writes($sformatf("R4/R5/R6/R7/R8 frame %0d", i));
      idx = (idx + FR_NDSC[i]) % 4;
    end

    // R9: chain out of ring and back
    arm_ring();
    mem[(dadr(idx) >> 2) + 1] = 32'h0100_0000;
    mem[(dadr(idx) >> 2) + 3] = 32'h200;
    mem[32'h200 >> 2]         = 32'h8000_0000;
    mem[(32'h200 >> 2) + 1]   = 32'h0300_0000;  // chain wins over end of ring
    mem[(32'h200 >> 2) + 3]   = BASE;
    snap = t_cnt;
    send_frame(6, 4);
    e_n = 3;
    e_addr[0] = dadr(idx); e_data[0] = st(0, 1, 0, 0, 0);
    e_addr[1] = dadr(idx); e_data[1] = st(1, 0, 1, 4, 6);
    e_addr[2] = 32'h200;   e_data[2] = st(1, 0, 1, 4, 6);
    cmp_writes("R9 chained next pointer");
    begin
      bit seen = 0;
      for (int k = snap; k < t_cnt; k++) if (!t_we[k] && t_addr[k] == dadr(idx) + 12) seen = 1;
      chk(seen, "R2 pointer read when chained", 32'(seen), 32'h1);
    end
    arm_ring();
    idx = 0;
    snap = t_cnt;
    send_frame(2, 0);
    exp_frame(0, 1, 0, 2);
    cmp_writes("R9 chain returns to ring");
    idx = 1;

    // R10: descriptor unavailable mid-frame
    arm_ring();
    mem[dadr(2) >> 2] = 32'h0;
    snap = t_cnt;
    send_frame(7, 1);
    e_n = 1; e_addr[0] = dadr(1); e_data[0] = st(0, 1, 0, 0, 0);
    cmp_writes("R10 only early release before stall");
    chk(desc_unavail_o, "R10 flag raised", 32'(desc_unavail_o), 32'h1);
    arm_ring();
    snap = t_cnt;
    send_frame(2, 2);
    exp_frame(2, 1, 2, 2);
    cmp_writes("R10 retry same descriptor");
    chk(!desc_unavail_o, "R10 flag cleared", 32'(desc_unavail_o), 32'h0);

    // R10: unavailable at start of frame
    arm_ring();
    mem[dadr(3) >> 2] = 32'h0;
    snap = t_cnt;
    send_frame(3, 0);
    e_n = 0;
    cmp_writes("R10 frame dropped at start");
    chk(desc_unavail_o, "R10 flag at start", 32'(desc_unavail_o), 32'h1);

    chk(hold_viol == 0, "R11 request held until ack", 32'(hold_viol), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule